// File: doc/BRIEF.md
# Shared-Logic Carry-Select Adder

This block adds two unsigned operands and an incoming carry without any clock, giving a sum of the operand width and a carry-out. It is a carry-select adder that does not use a second adder for each bit. Each bit cell forms one sum-and-carry pair for an incoming carry of zero: the XOR and the AND of its operand bits. It then forms the pair for an incoming carry of one from the same terms. That sum is the inverted XOR, and that carry is the OR of the two operand bits. A multiplexer at each bit picks one pair, driven by the carry selected at the bit below.

The bits are grouped, and the group sizes grow in the square-root style. Every group resolves its internal ripple twice, once for each value of its incoming carry, while the real carry is still on its way. When that carry arrives, a single multiplexer per group picks the matching sum bits and the matching group carry. The select network is kept apart from the bit datapath. The carry chain that remains runs once per group rather than once per bit.

Top module: `csa_adder`

## Requirements
- R1: For every pair of operands and every carry-in, `{carryOut, sum}` equals the WIDTH+1-bit sum `opA + opB + carryIn`.
- R2: With both operands all ones and carryIn = 1, sum is all ones and carryOut is 1.
- R3: With opA all ones, opB zero and carryIn = 1, the carry crosses every group: sum is zero and carryOut is 1.
- R4: The carry selected into the first group is carryIn. The carry selected into every later group equals bit `base` of the sum of the operand bits below `base` plus carryIn, where `base` is that group's lowest bit.
- R5: With fixed operands, changing carryIn from 0 to 1 inverts sum bit 0.
- R6: Group sizes follow this rule: group 0 and group 1 are FIRST_GROUP bits wide (default 2), each later group is one bit wider than the one before, and the last group is cut short at WIDTH. This puts the group boundaries at bits 2, 4, 7 and 11 for 16 bits, at bits 2, 4 and 7 for 8 bits, and at bits 2, 4, 7, 11, 16, 22 and 29 for 32 bits. A carry generated just below a boundary lands on the boundary bit.
- R7: With both operands zero and carryIn = 0, sum and carryOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand, unsigned |
| opB | input | WIDTH | Second operand, unsigned |
| carryIn | input | 1 | Incoming carry |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
All results are purely combinational, so every output is due in the same cycle as the operands that produce it, with no register on the path. The bench drives each input set between clock edges, waits a fixed settling delay and samples before the next input set is applied. No check depends on an edge. The 8-bit instance is checked exhaustively. The 16-bit and 32-bit instances get directed patterns that land on each group boundary, plus random operands.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Nominal width of group idx: the first two share the base size,
  // each later one grows by a bit.
  function automatic int nominalWidth(input int first, input int idx);
    return (idx == 0) ? first : first + idx - 1;
  endfunction

  function automatic int groupCount(input int width, input int first);
    int acc;
    int n;
    acc = 0;
    n = 0;
    while (acc < width) begin
      acc += nominalWidth(first, n);
      n++;
    end
    return n;
  endfunction

  function automatic int groupBase(input int width, input int first, input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += nominalWidth(first, k);
    return (acc > width) ? width : acc;
  endfunction

  function automatic int groupWidth(input int width, input int first, input int idx);
    int base;
    int nom;
    base = groupBase(width, first, idx);
    nom = nominalWidth(first, idx);
    return (base + nom > width) ? width - base : nom;
  endfunction

endpackage

// File: rtl/shared_bit_cell.sv
module shared_bit_cell (
  input  logic a,
  input  logic b,
  output logic sumC0,
  output logic carryC0,
  output logic sumC1,
  output logic carryC1
);
  // Terms for carry-in 0; carry-in 1 terms reuse them.
  assign sumC0   = a ^ b;
  assign carryC0 = a & b;
  assign sumC1   = ~sumC0;
  assign carryC1 = a | b;
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  output logic [GW-1:0] sumIf0,
  output logic [GW-1:0] sumIf1,
  output logic          coutIf0,
  output logic          coutIf1
);
  logic [GW-1:0] sC0, cC0, sC1, cC1;
  logic [1:0][GW-1:0] chainSum;
  logic [1:0] chainCout;

  for (genvar j = 0; j < GW; j++) begin : g_bit
    shared_bit_cell u_cell (
      .a(a[j]), .b(b[j]),
      .sumC0(sC0[j]), .carryC0(cC0[j]),
      .sumC1(sC1[j]), .carryC1(cC1[j])
    );
  end

  // Two ripple-select chains, one per assumed group carry-in.
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      logic r;
      r = 1'(k);
      for (int j = 0; j < GW; j++) begin
        chainSum[k][j] = r ? sC1[j] : sC0[j];
        r = r ? cC1[j] : cC0[j];
      end
      chainCout[k] = r;
    end
  end

  assign sumIf0  = chainSum[0];
  assign sumIf1  = chainSum[1];
  assign coutIf0 = chainCout[0];
  assign coutIf1 = chainCout[1];
endmodule

// File: rtl/csa_datapath.sv
module csa_datapath #(
  parameter int WIDTH       = 16,
  parameter int FIRST_GROUP = 2,
  localparam int NUM_GROUPS = csa_pkg::groupCount(WIDTH, FIRST_GROUP)
) (
  input  logic [WIDTH-1:0]      opA,
  input  logic [WIDTH-1:0]      opB,
  input  logic [NUM_GROUPS-1:0] grpCin,
  output logic [NUM_GROUPS-1:0] grpCout0,
  output logic [NUM_GROUPS-1:0] grpCout1,
  output logic [WIDTH-1:0]      sum
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int BASE = csa_pkg::groupBase(WIDTH, FIRST_GROUP, g);
    localparam int GW   = csa_pkg::groupWidth(WIDTH, FIRST_GROUP, g);
    logic [GW-1:0] sumIf0, sumIf1;

    csa_group #(.GW(GW)) u_grp (
      .a(opA[BASE +: GW]), .b(opB[BASE +: GW]),
      .sumIf0(sumIf0), .sumIf1(sumIf1),
      .coutIf0(grpCout0[g]), .coutIf1(grpCout1[g])
    );

    assign sum[BASE +: GW] = grpCin[g] ? sumIf1 : sumIf0;
  end
endmodule

// File: rtl/csa_select.sv
module csa_select #(
  parameter int NUM_GROUPS = 5
) (
  input  logic                  carryIn,
  input  logic [NUM_GROUPS-1:0] grpCout0,
  input  logic [NUM_GROUPS-1:0] grpCout1,
  output logic [NUM_GROUPS-1:0] grpCin,
  output logic                  carryOut
);
  // One mux per group on the carry path.
  always_comb begin
    logic c;
    c = carryIn;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      grpCin[g] = c;
      c = c ? grpCout1[g] : grpCout0[g];
    end
    carryOut = c;
  end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH       = 16,
  parameter int FIRST_GROUP = 2
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  localparam int NUM_GROUPS = csa_pkg::groupCount(WIDTH, FIRST_GROUP);

  logic [NUM_GROUPS-1:0] grpCin, grpCout0, grpCout1;

  csa_datapath #(.WIDTH(WIDTH), .FIRST_GROUP(FIRST_GROUP)) u_dp (
    .opA(opA), .opB(opB), .grpCin(grpCin),
    .grpCout0(grpCout0), .grpCout1(grpCout1), .sum(sum)
  );

  csa_select #(.NUM_GROUPS(NUM_GROUPS)) u_sel (
    .carryIn(carryIn), .grpCout0(grpCout0), .grpCout1(grpCout1),
    .grpCin(grpCin), .carryOut(carryOut)
  );
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
  parameter int WIDTH       = 16,
  parameter int FIRST_GROUP = 2,
  parameter int NUM_GROUPS  = 5
) (
  input logic [WIDTH-1:0]      opA,
  input logic [WIDTH-1:0]      opB,
  input logic                  carryIn,
  input logic [WIDTH-1:0]      sum,
  input logic                  carryOut,
  input logic [NUM_GROUPS-1:0] grpCin,
  input logic [NUM_GROUPS-1:0] grpCout0,
  input logic [NUM_GROUPS-1:0] grpCout1
);
  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    p_total_r1: assert ({carryOut, sum} == refTotal);
    p_first_cin_r4: assert (grpCin[0] == carryIn);
    if (opA == '0 && opB == '0 && !carryIn)
      p_zero_r7: assert (sum == '0 && !carryOut);
    for (int g = 0; g < NUM_GROUPS; g++) begin
      int base;
      logic [WIDTH:0] mask;
      logic [WIDTH:0] low;
      // A carry assumed in can only add carries out.
      p_cand_order_r4: assert (!grpCout0[g] || grpCout1[g]);
      base = csa_pkg::groupBase(WIDTH, FIRST_GROUP, g);
      mask = ({{WIDTH{1'b0}}, 1'b1} << base) - 1'b1;
      low = ({1'b0, opA} & mask) + ({1'b0, opB} & mask) + {{WIDTH{1'b0}}, carryIn};
      p_grp_cin_r4: assert (grpCin[g] == low[base]);
    end
  end
endmodule

bind csa_adder csa_adder_chk #(
  .WIDTH(WIDTH), .FIRST_GROUP(FIRST_GROUP), .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sum(sum), .carryOut(carryOut),
  .grpCin(grpCin), .grpCout0(grpCout0), .grpCout1(grpCout1)
);

// File: tb/csa_adder_tb.sv
module csa_adder_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [7:0]  a8,  b8;  logic c8;  logic [7:0]  s8;  logic co8;
  logic [15:0] a16, b16; logic c16; logic [15:0] s16; logic co16;
  logic [31:0] a32, b32; logic c32; logic [31:0] s32; logic co32;

  csa_adder #(.WIDTH(16)) u_dut (
    .opA(a16), .opB(b16), .carryIn(c16), .sum(s16), .carryOut(co16));
  csa_adder #(.WIDTH(8)) u_dut8 (
    .opA(a8), .opB(b8), .carryIn(c8), .sum(s8), .carryOut(co8));
  csa_adder #(.WIDTH(32)) u_dut32 (
    .opA(a32), .opB(b32), .carryIn(c32), .sum(s32), .carryOut(co32));

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c);
    a16 = a; b16 = b; c16 = c; #2;
  endtask
  task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
    a32 = a; b32 = b; c32 = c; #2;
  endtask
  task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic c);
    a8 = a; b8 = b; c8 = c; #1;
  endtask

  // R7: zero inputs give zero outputs on all widths
  task automatic t_zero();
    drive8(0, 0, 0); drive16(0, 0, 0); drive32(0, 0, 0);
    check("R7 w8",  {24'd0, co8, s8},   33'd0);
    check("R7 w16", {16'd0, co16, s16}, 33'd0);
    check("R7 w32", {co32, s32},        33'd0);
  endtask

  // R2: all ones plus all ones plus one
  task automatic t_all_ones();
    drive16('1, '1, 1'b1);
    check("R2 w16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'hFFFF});
    drive32('1, '1, 1'b1);
    check("R2 w32", {co32, s32}, {1'b1, 32'hFFFF_FFFF});
  endtask

  // R3: carry-in travels across every group
  task automatic t_full_ripple();
    drive16('1, 0, 1'b1);
    check("R3 w16", {16'd0, co16, s16}, {16'd0, 1'b1, 16'h0000});
    drive32('1, 0, 1'b1);
    check("R3 w32", {co32, s32}, {1'b1, 32'h0});
    drive8('1, 0, 1'b1);
    check("R3 w8", {24'd0, co8, s8}, {24'd0, 1'b1, 8'h00});
  endtask

  // R4 / R6: carries generated just below each group boundary
  task automatic t_boundaries();
    int b16s[4] = '{2, 4, 7, 11};
    int b32s[7] = '{2, 4, 7, 11, 16, 22, 29};
    foreach (b16s[i]) begin
      logic [15:0] m;
      m = 16'((17'd1 << b16s[i]) - 17'd1);
      drive16(m, 16'd1, 1'b0);
      check("R6 w16 generate", {17'd0, s16}, {17'd0, 16'(17'd1 << b16s[i])});
      drive16(m, 16'd0, 1'b1);
      check("R4 w16 carry-in", {17'd0, s16}, {17'd0, 16'(17'd1 << b16s[i])});
    end
    foreach (b32s[i]) begin
      logic [31:0] m;
      m = 32'((33'd1 << b32s[i]) - 33'd1);
      drive32(m, 32'd1, 1'b0);
      check("R6 w32 generate", {1'b0, s32}, {1'b0, 32'(33'd1 << b32s[i])});
    end
    drive8(8'h7F, 8'h01, 1'b0);
    check("R6 w8 last group", {24'd0, co8, s8}, {24'd0, 1'b0, 8'h80});
    drive8(8'hFF, 8'h01, 1'b0);
    check("R6 w8 carry out", {24'd0, co8, s8}, {24'd0, 1'b1, 8'h00});
  endtask

  // R5: carry-in toggle inverts bit 0
  task automatic t_cin_flip();
    logic [15:0] pa[3] = '{16'h1234, 16'hFFFF, 16'h0F0F};
    logic [15:0] pb[3] = '{16'h4321, 16'h0000, 16'hF0F0};
    foreach (pa[i]) begin
      logic s0;
      drive16(pa[i], pb[i], 1'b0);
      s0 = s16[0];
      drive16(pa[i], pb[i], 1'b1);
      check("R5 bit0 flip", {32'd0, s16[0]}, {32'd0, ~s0});
    end
  endtask

  // R1: exhaustive 8-bit
  task automatic t_exhaustive8();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          drive8(8'(a), 8'(b), 1'(c));
          check("R1 w8 exhaustive", {24'd0, co8, s8}, 33'(a + b + c));
        end
  endtask

  // R1: random 16 and 32 bit
  task automatic t_random();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b; logic c;
      a = 16'($urandom); b = 16'($urandom); c = 1'($urandom);
      drive16(a, b, c);
      check("R1 w16 random", {16'd0, co16, s16}, 33'({17'd0, a} + {17'd0, b} + {32'd0, c}));
    end
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b; logic c;
      a = $urandom; b = $urandom; c = 1'($urandom);
      drive32(a, b, c);
      check("R1 w32 random", {co32, s32}, {1'b0, a} + {1'b0, b} + {32'd0, c});
    end
  endtask

  initial begin
    void'($urandom(7));
    a8 = 0; b8 = 0; c8 = 0; a16 = 0; b16 = 0; c16 = 0; a32 = 0; b32 = 0; c32 = 0;
    @(posedge clk); #1;
    t_zero();
    t_all_ones();
    t_full_ripple();
    t_boundaries();
    t_cin_flip();
    t_exhaustive8();
    t_random();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule